// File: doc/BRIEF.md
# Shared-Pool Virtual-Channel Crossbar Switch

This block is an on-chip switch that links a small set of endpoints, four by default. Each endpoint sends and receives flits on several virtual channels. Flits wait at the input side only. All virtual channels at an input draw their storage from one common pool of flit slots. Inside the pool, each channel keeps its own chain of slot indices, so flits on a channel leave in the order they arrived. The shared pool needs far less storage than separate per-channel queues of the same peak depth.

A packet is a head flit, optional body flits, and a tail flit. A single-flit packet sets both marks. The low bits of the head flit's data name the output port. Each output uses a rotating-priority arbiter and stays with one packet from its head to its tail. Each input sends at most one flit per cycle, and different outputs can carry flits in the same cycle. An output never back-pressures. Flow control runs only on credits: each flit that leaves returns one credit, tagged with its channel, to the sender at that input.

The sender must obey one rule. It may send on a channel if that channel has nothing stored, or if the slots held beyond the first by all channels of that input number fewer than DEPTH minus NV. This rule reserves one slot for every channel. A packet that holds an output can therefore always bring in its next flit, even when the rest of the pool is full.

Top module: `vc_xbar`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` and `cr_ret` are all zero. Every input pool then has all DEPTH slots free.
- R2: A head flit (`in_head`=1) chooses its output with data bits [PW-1:0]. Every flit of that packet leaves on that output with unchanged data, unchanged head and tail marks (`in_tail`=1 marks the tail), and unchanged channel number.
- R3: Each input has DEPTH shared slots. Under the sender rule above, one channel may hold DEPTH-NV+1 flits while each other channel can still store a flit. A flit written into the last free slot is stored and later delivered. A flit never arrives at a full pool.
- R4: Flits from the same input on the same channel leave in the order they arrived.
- R5: Once a head flit leaves on an output, only flits of the same input and channel appear there, up to and including the tail. Head flits from other sources that want that output wait.
- R6: Each input forwards at most one flit per cycle. Different outputs may carry flits in the same cycle.
- R7: In the cycle a flit appears on an output, `cr_ret` pulses for its input, and `cr_vc` carries that flit's channel. No credit appears without a departing flit.
- R8: On an idle switch, a flit driven before clock edge k is stored at edge k and appears on its output after edge k+1.
- R9: After an output grants input i, its search order on the next contested cycle starts at input i+1 and wraps. Two inputs that both keep requesting one output are therefore granted in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NP | One flit arrives at each input whose bit is set |
| in_head | input | NP | Arriving flit is a head |
| in_tail | input | NP | Arriving flit is a tail |
| in_vc | input | NP x VW | Channel of each arriving flit |
| in_data | input | NP x DW | Flit payload; head flits hold the destination port in bits [PW-1:0] |
| out_valid | output | NP | A flit leaves on each output whose bit is set |
| out_head | output | NP | Leaving flit is a head |
| out_tail | output | NP | Leaving flit is a tail |
| out_vc | output | NP x VW | Channel of each leaving flit |
| out_data | output | NP x DW | Payload of each leaving flit |
| cr_ret | output | NP | One credit returned to the sender at each input whose bit is set |
| cr_vc | output | NP x VW | Channel of the freed slot |

## Verification
The hardest state to reach is a full pool. In that state one channel fills every shared slot while a packet on another input holds the output it needs, and the one free slot is reserved for a different channel. No output ever stalls, so a buffer fills only behind a held output. A directed sequence first locks output 3 with a head flit whose tail is withheld. It then stacks seven single-flit packets for output 3 on one channel of input 0, and uses the last reserved slot with a flit on the other channel. Only after that does it release the tail and check the drain order. A random phase with hot-spot destinations and a sender model that follows the credit rule then reaches the same crowding many times at once.

// File: rtl/vc_xbar.sv
module vc_xbar #(
  parameter int NP = 4,
  parameter int NV = 2,
  parameter int DEPTH = 8,
  parameter int DW = 16,
  localparam int PW = $clog2(NP),
  localparam int VW = $clog2(NV)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NP-1:0]          in_valid,
  input  logic [NP-1:0]          in_head,
  input  logic [NP-1:0]          in_tail,
  input  logic [NP-1:0][VW-1:0]  in_vc,
  input  logic [NP-1:0][DW-1:0]  in_data,
  output logic [NP-1:0]          out_valid,
  output logic [NP-1:0]          out_head,
  output logic [NP-1:0]          out_tail,
  output logic [NP-1:0][VW-1:0]  out_vc,
  output logic [NP-1:0][DW-1:0]  out_data,
  output logic [NP-1:0]          cr_ret,
  output logic [NP-1:0][VW-1:0]  cr_vc
);
  localparam int SW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = DW + 2;

  logic [FW-1:0]    mem   [NP][DEPTH];
  logic [SW-1:0]    nxt   [NP][DEPTH];
  logic [SW-1:0]    hd    [NP][NV];
  logic [SW-1:0]    tl    [NP][NV];
  logic [CW-1:0]    cnt   [NP][NV];
  logic [PW-1:0]    rt    [NP][NV];
  logic [DEPTH-1:0] free  [NP];
  logic [VW-1:0]    vptr  [NP];
  logic [NP-1:0]    lock;
  logic [PW-1:0]    own_p [NP];
  logic [VW-1:0]    own_v [NP];
  logic [PW-1:0]    optr  [NP];

  logic [FW-1:0]    hf    [NP][NV];
  logic [PW-1:0]    tg    [NP][NV];
  logic             elig  [NP][NV];
  logic             pu    [NP][NV];
  logic             po    [NP][NV];
  logic [NP-1:0]    has_free;
  logic [SW-1:0]    aslot [NP];
  logic             req_ok[NP];
  logic [VW-1:0]    req_v [NP];
  logic [PW-1:0]    req_t [NP];
  logic [NP-1:0]    pop;
  logic             gnt_ok[NP];
  logic [PW-1:0]    gnt_i [NP];
  logic [FW-1:0]    gflit [NP];
  logic [VW-1:0]    gvc   [NP];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      has_free[p] = |free[p];
      aslot[p] = '0;
      for (int s = DEPTH - 1; s >= 0; s--)
        if (free[p][s]) aslot[p] = SW'(s);
      for (int v = 0; v < NV; v++) begin
        hf[p][v] = mem[p][hd[p][v]];
        tg[p][v] = hf[p][v][FW-1] ? hf[p][v][PW-1:0] : rt[p][v];
        elig[p][v] = (cnt[p][v] != '0) &&
                     (hf[p][v][FW-1] ? !lock[tg[p][v]]
                                     : (lock[tg[p][v]] && own_p[tg[p][v]] == PW'(p) &&
                                        own_v[tg[p][v]] == VW'(v)));
      end
      req_ok[p] = 1'b0;
      req_v[p] = '0;
      for (int k = 0; k < NV; k++)
        if (!req_ok[p] && elig[p][VW'(vptr[p] + VW'(k))]) begin
          req_ok[p] = 1'b1;
          req_v[p] = VW'(vptr[p] + VW'(k));
        end
      req_t[p] = tg[p][req_v[p]];
    end
    for (int o = 0; o < NP; o++) begin
      gnt_ok[o] = 1'b0;
      gnt_i[o] = '0;
      for (int k = 0; k < NP; k++)
        if (!gnt_ok[o] && req_ok[PW'(optr[o] + PW'(k))] &&
            req_t[PW'(optr[o] + PW'(k))] == PW'(o)) begin
          gnt_ok[o] = 1'b1;
          gnt_i[o] = PW'(optr[o] + PW'(k));
        end
      gvc[o] = req_v[gnt_i[o]];
      gflit[o] = hf[gnt_i[o]][gvc[o]];
    end
    for (int p = 0; p < NP; p++) begin
      pop[p] = req_ok[p] && gnt_ok[req_t[p]] && gnt_i[req_t[p]] == PW'(p);
      for (int v = 0; v < NV; v++) begin
        pu[p][v] = in_valid[p] && has_free[p] && in_vc[p] == VW'(v);
        po[p][v] = pop[p] && req_v[p] == VW'(v);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock <= '0;
      out_valid <= '0;
      out_head <= '0;
      out_tail <= '0;
      out_vc <= '0;
      out_data <= '0;
      cr_ret <= '0;
      cr_vc <= '0;
      for (int p = 0; p < NP; p++) begin
        free[p] <= '1;
        vptr[p] <= '0;
        own_p[p] <= '0;
        own_v[p] <= '0;
        optr[p] <= '0;
        for (int v = 0; v < NV; v++) begin
          cnt[p][v] <= '0;
          hd[p][v] <= '0;
          tl[p][v] <= '0;
          rt[p][v] <= '0;
        end
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        cr_ret[p] <= pop[p];
        cr_vc[p] <= req_v[p];
        free[p] <= (free[p] & ~((in_valid[p] && has_free[p]) ? (DEPTH'(1) << aslot[p]) : '0))
                 | (pop[p] ? (DEPTH'(1) << hd[p][req_v[p]]) : '0);
        if (in_valid[p] && has_free[p])
          mem[p][aslot[p]] <= {in_head[p], in_tail[p], in_data[p]};
        if (pop[p]) vptr[p] <= VW'(req_v[p] + 1'b1);
        for (int v = 0; v < NV; v++) begin
          cnt[p][v] <= cnt[p][v] + CW'(pu[p][v]) - CW'(po[p][v]);
          if (pu[p][v]) tl[p][v] <= aslot[p];
          if (pu[p][v] && cnt[p][v] != '0) nxt[p][tl[p][v]] <= aslot[p];
          if (po[p][v]) hd[p][v] <= (cnt[p][v] == CW'(1)) ? aslot[p] : nxt[p][hd[p][v]];
          else if (pu[p][v] && cnt[p][v] == '0) hd[p][v] <= aslot[p];
          if (po[p][v] && hf[p][v][FW-1]) rt[p][v] <= tg[p][v];
        end
      end
      for (int o = 0; o < NP; o++) begin
        out_valid[o] <= gnt_ok[o];
        if (gnt_ok[o]) begin
          out_head[o] <= gflit[o][FW-1];
          out_tail[o] <= gflit[o][FW-2];
          out_data[o] <= gflit[o][DW-1:0];
          out_vc[o] <= gvc[o];
          optr[o] <= PW'(gnt_i[o] + 1'b1);
          if (gflit[o][FW-2]) lock[o] <= 1'b0;
          else if (gflit[o][FW-1]) begin
            lock[o] <= 1'b1;
            own_p[o] <= gnt_i[o];
            own_v[o] <= gvc[o];
          end
        end
      end
    end
  end
endmodule

// File: rtl/vc_xbar_chk.sv
module vc_xbar_chk #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] in_valid,
  input logic [NP-1:0] has_free,
  input logic [NP-1:0] out_valid,
  input logic [NP-1:0] out_head,
  input logic [NP-1:0] out_tail,
  input logic [NP-1:0] cr_ret
);
  logic [NP-1:0] mid;

  always_ff @(posedge clk) begin
    if (rst) mid <= '0;
    else
      for (int o = 0; o < NP; o++)
        if (out_valid[o]) mid[o] <= !out_tail[o];
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0 && cr_ret == '0));

  p_credit_per_flit_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(out_valid) == $countones(cr_ret));

  for (genvar g = 0; g < NP; g++) begin : g_port
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      in_valid[g] |-> has_free[g]);
    p_body_inside_packet_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid[g] && mid[g]) |-> !out_head[g]);
    p_packet_opens_with_head_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid[g] && !mid[g]) |-> out_head[g]);
  end
endmodule

bind vc_xbar vc_xbar_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .has_free(has_free),
  .out_valid(out_valid), .out_head(out_head), .out_tail(out_tail), .cr_ret(cr_ret)
);

// File: tb/vc_xbar_test.sv
module vc_xbar_test;
  localparam int NP = 4, NV = 2, DEPTH = 8, DW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] in_valid = '0, in_head = '0, in_tail = '0;
  logic [NP-1:0][0:0] in_vc = '0;
  logic [NP-1:0][DW-1:0] in_data = '0;
  logic [NP-1:0] out_valid, out_head, out_tail, cr_ret;
  logic [NP-1:0][0:0] out_vc, cr_vc;
  logic [NP-1:0][DW-1:0] out_data;

  always #5 clk = ~clk;

  vc_xbar #(.NP(NP), .NV(NV), .DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
    .in_vc(in_vc), .in_data(in_data), .out_valid(out_valid), .out_head(out_head),
    .out_tail(out_tail), .out_vc(out_vc), .out_data(out_data), .cr_ret(cr_ret), .cr_vc(cr_vc));

  int total = 0, bad = 0, multi = 0;
  logic [19:0] expq [NP][NV][$];
  int sent [NP][NV], ret [NP][NV], seqc [NP][NV];
  int left [NP][NV], pdst [NP][NV];
  bit hnext [NP][NV];
  bit mid [NP];
  int own_s [NP], own_v [NP];
  int log2 [$], log3 [$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit can_send(int p, int v);
    int sh = 0;
    for (int w = 0; w < NV; w++)
      if (sent[p][w] - ret[p][w] > 1) sh += sent[p][w] - ret[p][w] - 1;
    return (sent[p][v] - ret[p][v] == 0) || (sh < DEPTH - NV);
  endfunction

  task automatic sample();
    int dep [NP];
    int dvc [NP];
    for (int p = 0; p < NP; p++) begin dep[p] = 0; dvc[p] = 0; end
    for (int o = 0; o < NP; o++) begin
      if (out_valid[o]) begin
        int s = int'(out_data[o][15:14]);
        int v = int'(out_vc[o]);
        logic [19:0] e;
        dep[s]++;
        dvc[s] = v;
        if (o == 2) log2.push_back(s);
        if (o == 3) log3.push_back(s);
        if (expq[s][v].size() == 0) chk(0, "R4", "flit with no pending entry", s, -1);
        else begin
          e = expq[s][v].pop_front();
          chk(o == int'(e[19:18]), "R2", "output port", o, int'(e[19:18]));
          chk(out_data[o] == e[15:0], "R4", "data in channel order", int'(out_data[o]), int'(e[15:0]));
          chk({out_head[o], out_tail[o]} == e[17:16], "R2", "head/tail marks",
              int'({out_head[o], out_tail[o]}), int'(e[17:16]));
        end
        if (mid[o]) chk(!out_head[o] && s == own_s[o] && v == own_v[o], "R5",
                        "flit source inside held packet", s, own_s[o]);
        else chk(out_head[o], "R5", "packet opens with head", int'(out_head[o]), 1);
        if (out_head[o]) begin own_s[o] = s; own_v[o] = v; end
        mid[o] = !out_tail[o];
      end
    end
    for (int p = 0; p < NP; p++) begin
      if (dep[p] != 0 || cr_ret[p]) begin
        chk(dep[p] <= 1, "R6", "flits from one input in a cycle", dep[p], 1);
        chk(int'(cr_ret[p]) == (dep[p] > 0 ? 1 : 0), "R7", "credit pulse", int'(cr_ret[p]), dep[p]);
      end
      if (cr_ret[p]) begin
        chk(int'(cr_vc[p]) == dvc[p], "R7", "credit channel", int'(cr_vc[p]), dvc[p]);
        ret[p][cr_vc[p]]++;
      end
    end
    if ($countones(out_valid) > 1) multi++;
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) sample();
    in_valid = '0;
    in_head = '0;
    in_tail = '0;
  endtask

  task automatic send(int p, int v, bit h, bit t, int d);
    logic [15:0] w = {p[1:0], seqc[p][v][7:0], 4'b0, d[1:0]};
    seqc[p][v]++;
    in_valid[p] = 1'b1;
    in_head[p] = h;
    in_tail[p] = t;
    in_vc[p] = v[0:0];
    in_data[p] = w;
    expq[p][v].push_back({d[1:0], h, t, w});
    sent[p][v]++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) begin
      mid[p] = 0; own_s[p] = 0; own_v[p] = 0;
      for (int v = 0; v < NV; v++) begin
        sent[p][v] = 0; ret[p][v] = 0; seqc[p][v] = 0; left[p][v] = 0; pdst[p][v] = 0; hnext[p][v] = 0;
      end
    end
    repeat (3) tick();
    chk(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(cr_ret == '0, "R1", "cr_ret in reset", int'(cr_ret), 0);
    rst = 1'b0;
    tick();
    chk(out_valid == '0 && cr_ret == '0, "R1", "idle after reset", int'(out_valid | cr_ret), 0);

    // R8: latency on an idle switch, input 3 channel 1 to output 1
    send(3, 1, 1, 1, 1);
    tick();
    chk(out_valid == '0, "R8", "nothing out one edge after arrival", int'(out_valid), 0);
    tick();
    chk(out_valid == 4'b0010, "R8", "flit out after second edge", int'(out_valid), 2);
    chk(cr_ret == 4'b1000 && cr_vc[3] == 1'b1, "R7", "credit to input 3 channel 1",
        int'(cr_ret), 8);
    repeat (3) tick();

    // R9: inputs 0 and 1 contend for output 2
    log2.delete();
    for (int c = 0; c < 12; c++) begin
      if (c < 3) begin send(0, 0, 1, 1, 2); send(1, 0, 1, 1, 2); end
      tick();
    end
    chk(log2.size() == 6, "R9", "flits through output 2", log2.size(), 6);
    for (int i = 0; i < 6 && i < log2.size(); i++)
      chk(log2[i] == i % 2, "R9", "alternating source", log2[i], i % 2);

    // R3/R5: full pool behind a held output
    send(1, 0, 1, 0, 3);
    repeat (4) tick();
    log3.delete();
    for (int i = 0; i < 7; i++) begin
      chk(can_send(0, 1), "R3", "sender rule admits shared slot", 0, 1);
      send(0, 1, 1, 1, 3);
      tick();
    end
    repeat (3) tick();
    chk(log3.size() == 0, "R5", "held output passes no other head", log3.size(), 0);
    chk(ret[0][1] == 0, "R3", "stacked flits still stored", ret[0][1], 0);
    chk(can_send(0, 0), "R3", "reserved slot for idle channel", 0, 1);
    send(0, 0, 1, 1, 0);
    tick();
    tick();
    chk(out_valid[0] == 1'b1, "R3", "last slot flit delivered", int'(out_valid[0]), 1);
    send(1, 0, 0, 1, 3);
    repeat (14) tick();
    chk(log3.size() == 8, "R5", "flits through output 3", log3.size(), 8);
    if (log3.size() == 8) begin
      chk(log3[0] == 1, "R5", "tail of holding packet first", log3[0], 1);
      for (int i = 1; i < 8; i++) chk(log3[i] == 0, "R4", "stacked flits follow", log3[i], 0);
    end
    chk(ret[0][1] == 7, "R7", "credits for stacked channel", ret[0][1], 7);

    // random phase with a hot output
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NP; p++) begin
        if ($urandom % 100 < 70) begin
          int v = int'($urandom % NV);
          if (left[p][v] == 0) begin
            left[p][v] = 1 + int'($urandom % 4);
            pdst[p][v] = ($urandom % 2) ? 0 : int'($urandom % NP);
            hnext[p][v] = 1;
          end
          if (can_send(p, v)) begin
            send(p, v, hnext[p][v], left[p][v] == 1, pdst[p][v]);
            hnext[p][v] = 0;
            left[p][v]--;
          end
        end
      end
      tick();
    end
    for (int c = 0; c < 2000; c++) begin
      int pend = 0;
      for (int p = 0; p < NP; p++)
        for (int v = 0; v < NV; v++)
          if (left[p][v] > 0 && can_send(p, v)) begin
            if (in_valid[p] == 1'b0) begin
              send(p, v, hnext[p][v], left[p][v] == 1, pdst[p][v]);
              hnext[p][v] = 0;
              left[p][v]--;
            end
          end
      tick();
      for (int p = 0; p < NP; p++)
        for (int v = 0; v < NV; v++) pend += expq[p][v].size() + left[p][v];
      if (pend == 0) break;
    end
    repeat (4) tick();
    for (int p = 0; p < NP; p++)
      for (int v = 0; v < NV; v++) begin
        chk(expq[p][v].size() == 0, "R4", "undelivered flits", expq[p][v].size(), 0);
        chk(sent[p][v] == ret[p][v], "R7", "all credits returned", ret[p][v], sent[p][v]);
      end
    chk(multi > 0, "R6", "cycles with several outputs busy", multi, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule